// File: doc/BRIEF.md
# Static Memory Bank Controller

This block runs the external bus cycles for four chip-selected static memory banks. A host hands it one request at a time (address, direction, size, write data and a sequential hint) over a valid/ready port. The block decodes the bank from the address and drives the chip select, address, output enable, write enable, byte lanes and data bus of that bank. It counts that bank's programmed wait states and then returns a one-cycle response carrying the assembled read data, or an error flag if the write was refused.

Each bank carries its own configuration word, written through a separate register port. The word sets the memory type, the bus and device widths, separate read and write wait counts, first and follow-on timing for burst-mode ROM, the read-to-write turnaround gap, and a write-protect flag. Accesses wider than the external bus are split into sequential bus cycles. An active-low wait input from the device can stretch any access for as long as it stays low.

Top module: `static_bank_ctrl`

## Requirements
- R1: Address bits [27:26] pick the bank, and only the matching active-low chip select goes low during a bus cycle. Bits [31:28] and [25:24] have no effect. The address of the current beat is driven on the 24 address pins.
- R2: A configuration write replaces the word of the bank given by `cfgBank`. The word holds: read wait [4:0], write wait [9:5], burst first wait [14:10], burst follow-on wait [19:15], turnaround [23:20], type [25:24] (0 RAM, 1 ROM, 2 flash, 3 burst ROM), 16-bit bus [26], 16-bit device [27] and write protect [28]. After reset every bank is a 16-bit ROM on a 16-bit bus with all wait and turnaround fields at their maximum, so a read is 32 cycles long.
- R3: On a non-burst bank, output enable stays low for read-wait+1 cycles per beat. Data is sampled on the last of those cycles, and the response is valid in the following cycle.
- R4: A write beat first spends one cycle with chip select and data driven and write enable high. Write enable then stays low for write-wait+1 cycles while the data is held.
- R5: On a burst-ROM bank, the first beat of a read lasts burst-first+1 cycles. Later beats of the same request last burst-follow-on+1 cycles. The first beat of a request also takes the follow-on timing when the request is marked sequential and the previous bus cycle was a read of the same bank.
- R6: While `memWaitN` is low during an access, the access is held and the cycle count does not finish. Each low cycle lengthens the access by one.
- R7: When a write follows a read, all chip selects stay high for turnaround+1 cycles before the write setup cycle.
- R8: A write to a write-protected bank never lowers write enable or any chip select. The next cycle it responds with `rspErr` high, and memory is left unchanged.
- R9: On a 16-bit bus, a word access is two beats: the low halfword at the address, then the high halfword at the address plus 2. A byte access drives the byte on both lanes and selects the lane given by address bit 0.
- R10: On an 8-bit bus, each byte is its own beat on lane 0 at consecutive addresses. Read bytes are assembled little-endian before the response.
- R11: The byte-lane outputs are active low. For a 16-bit device they are asserted during the whole bus cycle. For an 8-bit device they are asserted only while write enable is low. They are high when the bus is idle.
- R12: `reqReady` is high only when no request is in progress. `rspValid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block idle and accepting a request |
| reqAddr | input | 32 | Request byte address |
| reqWrite | input | 1 | 1 write, 0 read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqSeq | input | 1 | Request continues the previous read burst |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response pulse |
| rspErr | output | 1 | Write refused by protection |
| rspRdata | output | 32 | Assembled read data |
| cfgWe | input | 1 | Configuration write strobe |
| cfgBank | input | 2 | Bank whose configuration is written |
| cfgData | input | 32 | Configuration word |
| memCsN | output | 4 | Active-low chip selects |
| memAddr | output | 24 | External address |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memBeN | output | 2 | Active-low byte lanes |
| memDout | output | 16 | Data driven to the bus |
| memDoe | output | 1 | Data bus drive enable |
| memDin | input | 16 | Data returned from the bus |
| memWaitN | input | 1 | Active-low wait from device |

## Verification
Two functions can land on the same access. The external wait can stretch a beat whose length is already set by a burst-ROM count, and a turnaround gap can precede a write that is then split into several beats. The bench pulls the wait pin low during the first beat of a two-beat access. It also issues split writes right after reads, on banks with different gap settings. A reference procedure computes every expected pin level from the bank settings alone and judges each cycle. It also checks that the gap, the setup cycles and the stretched beat add up to exactly the expected response cycle.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int BANK_LSB  = 26;
  localparam int MEM_AW    = 24;
  localparam int BUS_W     = 16;
  localparam int HOST_W    = 32;
  localparam int WAIT_W    = 5;
  localparam int TURN_W    = 4;
  localparam int BEAT_W    = 2;

  typedef enum logic [1:0] {
    MT_RAM   = 2'd0,
    MT_ROM   = 2'd1,
    MT_FLASH = 2'd2,
    MT_BURST = 2'd3
  } memType_e;

  // Packed so that the first member lands in the highest bits.
  typedef struct packed {
    logic              wrProt;
    logic              devWide;
    logic              busWide;
    memType_e          memType;
    logic [TURN_W-1:0] turnGap;
    logic [WAIT_W-1:0] burstNext;
    logic [WAIT_W-1:0] burstFirst;
    logic [WAIT_W-1:0] wrWait;
    logic [WAIT_W-1:0] rdWait;
  } bankCfg_t;

  localparam int CFG_W = $bits(bankCfg_t);

  localparam bankCfg_t CFG_RESET = '{
    wrProt: 1'b0, devWide: 1'b1, busWide: 1'b1, memType: MT_ROM,
    turnGap: '1, burstNext: '1, burstFirst: '1, wrWait: '1, rdWait: '1
  };

  typedef struct packed {
    logic load;      // latch a new request
    logic nextBeat;  // advance to the following beat
    logic capture;   // sample read data of the current beat
    logic busOn;     // a bank is selected this cycle
    logic weOn;      // write enable is low this cycle
  } dpStrobe_t;
endpackage

// File: rtl/smem_datapath.sv
module smem_datapath
  import smem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [BANK_W-1:0] cfgBank,
  input  logic [31:0]       cfgData,
  input  logic [31:0]       reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [HOST_W-1:0] reqWdata,
  input  dpStrobe_t         strobe,
  input  logic [BUS_W-1:0]  memDin,
  output bankCfg_t          reqCfg,
  output bankCfg_t          curCfg,
  output logic [BANK_W-1:0] reqBank,
  output logic [BANK_W-1:0] curBank,
  output logic              curWrite,
  output logic              lastBeat,
  output logic [MEM_AW-1:0] memAddr,
  output logic [BUS_W-1:0]  memDout,
  output logic [1:0]        memBeN,
  output logic [HOST_W-1:0] rspRdata
);
  bankCfg_t            cfgRegs [NUM_BANKS];
  logic [MEM_AW-1:0]   addrQ;
  logic [1:0]          sizeQ;
  logic [HOST_W-1:0]   wdataQ;
  logic [HOST_W-1:0]   rdBuf;
  logic [BEAT_W-1:0]   beatQ;
  logic [BEAT_W:0]     nBeats;
  logic [HOST_W-1:0]   wdShift;
  logic [1:0]          lanes;
  logic                laneOn;
  logic                unusedBits;

  assign unusedBits = ^{reqAddr, cfgData};
  assign reqBank    = reqAddr[BANK_LSB +: BANK_W];
  assign reqCfg     = cfgRegs[reqBank];
  assign curCfg     = cfgRegs[curBank];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) cfgRegs[b] <= CFG_RESET;
    end else if (cfgWe) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (cfgBank == BANK_W'(b)) cfgRegs[b] <= bankCfg_t'(cfgData[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      sizeQ    <= '0;
      wdataQ   <= '0;
      curBank  <= '0;
      curWrite <= 1'b0;
      beatQ    <= '0;
      rdBuf    <= '0;
    end else if (strobe.load) begin
      addrQ    <= reqAddr[MEM_AW-1:0];
      sizeQ    <= reqSize;
      wdataQ   <= reqWdata;
      curBank  <= reqBank;
      curWrite <= reqWrite;
      beatQ    <= '0;
      rdBuf    <= '0;
    end else begin
      if (strobe.capture) begin
        if (curCfg.busWide) begin
          if (sizeQ == 2'd0) rdBuf[7:0] <= addrQ[0] ? memDin[15:8] : memDin[7:0];
          else               rdBuf[{beatQ[0], 4'b0} +: 16] <= memDin;
        end else begin
          rdBuf[{beatQ, 3'b0} +: 8] <= memDin[7:0];
        end
      end
      if (strobe.nextBeat) beatQ <= beatQ + 1'b1;
    end
  end

  // Number of bus beats for the latched size on the bank's bus width.
  always_comb begin
    if (curCfg.busWide) nBeats = sizeQ[1] ? 3'd2 : 3'd1;
    else                nBeats = sizeQ[1] ? 3'd4 : (sizeQ[0] ? 3'd2 : 3'd1);
  end
  assign lastBeat = ({1'b0, beatQ} == nBeats - 3'd1);

  assign memAddr = addrQ + (curCfg.busWide ? MEM_AW'({beatQ, 1'b0}) : MEM_AW'(beatQ));

  always_comb begin
    wdShift = wdataQ >> (curCfg.busWide ? {beatQ, 4'b0} : {1'b0, beatQ, 3'b0});
    if (curCfg.busWide) begin
      memDout = (sizeQ == 2'd0) ? {2{wdataQ[7:0]}} : wdShift[15:0];
      lanes   = (sizeQ == 2'd0) ? (addrQ[0] ? 2'b10 : 2'b01) : 2'b11;
    end else begin
      memDout = {8'h00, wdShift[7:0]};
      lanes   = 2'b01;
    end
    laneOn = curCfg.devWide ? strobe.busOn : strobe.weOn;
    memBeN = ~(lanes & {2{laneOn}});
  end

  assign rspRdata = rdBuf;
endmodule

// File: rtl/smem_control.sv
module smem_control
  import smem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSeq,
  input  logic [BANK_W-1:0] reqBank,
  input  bankCfg_t          reqCfg,
  input  bankCfg_t          curCfg,
  input  logic [BANK_W-1:0] curBank,
  input  logic              curWrite,
  input  logic              lastBeat,
  input  logic              memWaitN,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspErr,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memDoe,
  output dpStrobe_t         strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_SETUP, ST_ACCESS} state_e;

  state_e            state;
  logic [WAIT_W-1:0] cnt;
  logic              lastRead;
  logic [BANK_W-1:0] lastBank;
  logic              accept, protHit, seqHit, accDone, busOn;
  logic [WAIT_W-1:0] firstRd, nextRd;
  logic              unusedCfg;

  assign unusedCfg = ^{curCfg, reqCfg};

  assign accept  = (state == ST_IDLE) && reqValid;
  assign protHit = accept && reqWrite && reqCfg.wrProt;
  assign seqHit  = reqSeq && lastRead && (lastBank == reqBank);
  assign firstRd = (reqCfg.memType == MT_BURST) ?
                   (seqHit ? reqCfg.burstNext : reqCfg.burstFirst) : reqCfg.rdWait;
  assign nextRd  = (curCfg.memType == MT_BURST) ? curCfg.burstNext : curCfg.rdWait;
  assign accDone = (state == ST_ACCESS) && (cnt == '0) && memWaitN;
  assign busOn   = (state == ST_SETUP) || (state == ST_ACCESS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
      lastBank <= '0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= protHit || (accDone && lastBeat);
      rspErr   <= protHit;
      unique case (state)
        ST_IDLE: if (accept && !protHit) begin
          if (!reqWrite) begin
            state <= ST_ACCESS;
            cnt   <= firstRd;
          end else if (lastRead) begin
            state <= ST_TURN;
            cnt   <= WAIT_W'(reqCfg.turnGap);
          end else begin
            state <= ST_SETUP;
          end
        end
        ST_TURN: begin
          if (cnt == '0) state <= ST_SETUP;
          else           cnt   <= cnt - 1'b1;
        end
        ST_SETUP: begin
          state    <= ST_ACCESS;
          cnt      <= curCfg.wrWait;
          lastRead <= 1'b0;
        end
        ST_ACCESS: begin
          if (memWaitN) begin
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else begin
              if (!curWrite) begin
                lastRead <= 1'b1;
                lastBank <= curBank;
              end
              if (lastBeat)      state <= ST_IDLE;
              else if (curWrite) state <= ST_SETUP;
              else               cnt   <= nextRd;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++)
      memCsN[b] = !(busOn && (curBank == BANK_W'(b)));
  end

  assign reqReady = (state == ST_IDLE);
  assign memOeN   = !((state == ST_ACCESS) && !curWrite);
  assign memWeN   = !((state == ST_ACCESS) && curWrite);
  assign memDoe   = busOn && curWrite;

  assign strobe.load     = accept;
  assign strobe.nextBeat = accDone && !lastBeat;
  assign strobe.capture  = accDone && !curWrite;
  assign strobe.busOn    = busOn;
  assign strobe.weOn     = (state == ST_ACCESS) && curWrite;

  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));
  assert_oe_we_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    memOeN || memWeN);
  assert_setup_before_we_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(memDoe) && $past(memWeN)));
  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS && !memWaitN) |=> (state == ST_ACCESS && !rspValid));
  assert_turn_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqWrite && !reqCfg.wrProt && lastRead) |=> (state == ST_TURN));
  assert_prot_no_we_R8: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !curCfg.wrProt);
  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/static_bank_ctrl.sv
module static_bank_ctrl
  import smem_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic        reqSeq,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic        rspErr,
  output logic [31:0] rspRdata,
  input  logic        cfgWe,
  input  logic [1:0]  cfgBank,
  input  logic [31:0] cfgData,
  output logic [3:0]  memCsN,
  output logic [23:0] memAddr,
  output logic        memOeN,
  output logic        memWeN,
  output logic [1:0]  memBeN,
  output logic [15:0] memDout,
  output logic        memDoe,
  input  logic [15:0] memDin,
  input  logic        memWaitN
);
  bankCfg_t          reqCfg, curCfg;
  logic [BANK_W-1:0] reqBank, curBank;
  logic              curWrite, lastBeat;
  dpStrobe_t         strobe;

  smem_datapath dp_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgBank(cfgBank), .cfgData(cfgData),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSize(reqSize), .reqWdata(reqWdata),
    .strobe(strobe), .memDin(memDin), .reqCfg(reqCfg), .curCfg(curCfg),
    .reqBank(reqBank), .curBank(curBank), .curWrite(curWrite), .lastBeat(lastBeat),
    .memAddr(memAddr), .memDout(memDout), .memBeN(memBeN), .rspRdata(rspRdata)
  );

  smem_control ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqSeq(reqSeq),
    .reqBank(reqBank), .reqCfg(reqCfg), .curCfg(curCfg), .curBank(curBank),
    .curWrite(curWrite), .lastBeat(lastBeat), .memWaitN(memWaitN),
    .reqReady(reqReady), .rspValid(rspValid), .rspErr(rspErr), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .memDoe(memDoe), .strobe(strobe)
  );
endmodule

// File: tb/static_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module static_bank_ctrl_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqSeq = 0, cfgWe = 0, memWaitN = 1;
  logic [31:0] reqAddr = 0, reqWdata = 0, cfgData = 0;
  logic [1:0] reqSize = 0, cfgBank = 0;
  logic reqReady, rspValid, rspErr, memOeN, memWeN, memDoe;
  logic [31:0] rspRdata;
  logic [3:0] memCsN;
  logic [23:0] memAddr;
  logic [1:0] memBeN;
  logic [15:0] memDout, memDin;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mem [4][256];
  logic [7:0] expMem [4][256];
  int cRd[4], cWr[4], cBf[4], cBn[4], cTurn[4], cType[4];
  bit cBus16[4], cDev16[4], cProt[4];
  bit lastRd = 0;
  int lastBk = 0;

  always #10 clk = ~clk;

  static_bank_ctrl dut_i (.*);

  always_comb begin
    memDin = 16'h0000;
    for (int b = 0; b < 4; b++)
      if (!memCsN[b] && !memOeN) begin
        if (cBus16[b]) memDin = {mem[b][{memAddr[7:1], 1'b1}], mem[b][{memAddr[7:1], 1'b0}]};
        else           memDin = {8'h00, mem[b][memAddr[7:0]]};
      end
  end

  always @(posedge clk)
    for (int b = 0; b < 4; b++)
      if (!memCsN[b] && !memWeN) begin
        if (cBus16[b]) begin
          if (!memBeN[0]) mem[b][{memAddr[7:1], 1'b0}] <= memDout[7:0];
          if (!memBeN[1]) mem[b][{memAddr[7:1], 1'b1}] <= memDout[15:8];
        end else if (!memBeN[0]) mem[b][memAddr[7:0]] <= memDout[7:0];
      end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setCfg(input int b, input int rd, input int wr, input int bf, input int bn,
                        input int tn, input int ty, input bit b16, input bit d16, input bit pr);
    @(negedge clk);
    cfgWe = 1; cfgBank = 2'(b);
    cfgData = rd | (wr << 5) | (bf << 10) | (bn << 15) | (tn << 20) | (ty << 24)
            | (int'(b16) << 26) | (int'(d16) << 27) | (int'(pr) << 28);
    cRd[b] = rd; cWr[b] = wr; cBf[b] = bf; cBn[b] = bn; cTurn[b] = tn; cType[b] = ty;
    cBus16[b] = b16; cDev16[b] = d16; cProt[b] = pr;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic idleChk(input string tag);
    chk(memCsN == 4'hF, {tag, " R1 idle cs"}, 32'(memCsN), 32'hF);
    chk(memBeN == 2'b11, {tag, " R11 idle lanes"}, 32'(memBeN), 32'h3);
  endtask

  task automatic doAccess(input logic [31:0] addr, input bit wr, input logic [1:0] size,
                          input logic [31:0] wd, input bit seq, input int stall, input string tag);
    int b, a, nb, n, ba;
    bit seqHit;
    logic [3:0] csExp;
    logic [1:0] lanes;
    logic [15:0] dExp;
    logic [31:0] rExp;
    b = int'(addr[27:26]);
    a = int'(addr[23:0]);
    nb = cBus16[b] ? (size[1] ? 2 : 1) : (size[1] ? 4 : (size[0] ? 2 : 1));
    seqHit = (cType[b] == 3) && seq && lastRd && (lastBk == b);
    csExp = ~(4'b1 << b);
    @(negedge clk);
    chk(reqReady == 1'b1, {tag, " R12 ready idle"}, 32'(reqReady), 1);
    reqValid = 1; reqAddr = addr; reqWrite = wr; reqSize = size; reqWdata = wd; reqSeq = seq;
    @(negedge clk);
    reqValid = 0;
    if (wr && cProt[b]) begin
      chk(rspValid && rspErr, {tag, " R8 prot err"}, {30'b0, rspValid, rspErr}, 3);
      chk(memWeN && memCsN == 4'hF, {tag, " R8 no we"}, {27'b0, memWeN, memCsN}, 32'h1F);
      @(negedge clk);
      chk(!rspValid, {tag, " R12 pulse"}, 32'(rspValid), 0);
      return;
    end
    if (wr && lastRd) begin
      for (int t = 0; t <= cTurn[b]; t++) begin
        chk(memCsN == 4'hF && memWeN && memOeN, {tag, " R7 turn idle"},
            {26'b0, memWeN, memOeN, memCsN}, 32'h3F);
        chk(!reqReady, {tag, " R12 busy"}, 32'(reqReady), 0);
        @(negedge clk);
      end
    end
    for (int k = 0; k < nb; k++) begin
      ba = a + k * (cBus16[b] ? 2 : 1);
      if (cBus16[b]) begin
        lanes = (size == 0) ? (a[0] ? 2'b10 : 2'b01) : 2'b11;
        dExp = (size == 0) ? {2{wd[7:0]}} : 16'(wd >> (16 * k));
      end else begin
        lanes = 2'b01;
        dExp = {8'h00, 8'(wd >> (8 * k))};
      end
      if (wr) begin
        chk(memCsN == csExp, {tag, " R1 setup cs"}, 32'(memCsN), 32'(csExp));
        chk(memWeN && memDoe && memDout == dExp, {tag, " R4 setup"},
            {14'b0, memWeN, memDoe, memDout}, {16'h3, dExp});
        chk(memBeN == (cDev16[b] ? ~lanes : 2'b11), {tag, " R11 setup lanes"}, 32'(memBeN),
            32'(cDev16[b] ? ~lanes : 2'b11));
        @(negedge clk);
        n = cWr[b] + 1;
      end else if (cType[b] == 3) begin
        n = ((k == 0 && !seqHit) ? cBf[b] : cBn[b]) + 1;
      end else begin
        n = cRd[b] + 1;
      end
      for (int i = 1; i <= n + ((k == 0) ? stall : 0); i++) begin
        chk(memCsN == csExp, {tag, " R1 cs"}, 32'(memCsN), 32'(csExp));
        chk(32'(memAddr) == 32'(ba & 24'hFFFFFF), {tag, cBus16[b] ? " R9 addr" : " R10 addr"},
            32'(memAddr), 32'(ba));
        chk(memOeN == wr && memWeN == !wr, {tag, " strobe"}, {30'b0, memOeN, memWeN},
            {30'b0, wr, !wr});
        chk(!rspValid && !reqReady, {tag, " R12 busy"}, {30'b0, rspValid, reqReady}, 0);
        if (wr) begin
          chk(memDoe && memDout == dExp, {tag, " R4 data held"}, {15'b0, memDoe, memDout}, {16'h1, dExp});
          chk(memBeN == ~lanes, {tag, " R11 we lanes"}, 32'(memBeN), 32'(~lanes));
        end else begin
          chk(memBeN == (cDev16[b] ? ~lanes : 2'b11), {tag, " R11 rd lanes"}, 32'(memBeN),
              32'(cDev16[b] ? ~lanes : 2'b11));
        end
        memWaitN = !(k == 0 && i <= stall);
        @(negedge clk);
      end
      memWaitN = 1;
    end
    rExp = 0;
    for (int j = 0; j < (1 << (size[1] ? 2 : size)); j++) begin
      if (wr) expMem[b][(a + j) & 255] = wd[8 * j +: 8];
      else    rExp[8 * j +: 8] = expMem[b][(a + j) & 255];
    end
    chk(rspValid && !rspErr, {tag, " response cycle"}, {30'b0, rspValid, rspErr}, 2);
    idleChk(tag);
    if (!wr) begin
      chk(rspRdata == rExp, {tag, cBus16[b] ? " R9 rdata" : " R10 rdata"}, rspRdata, rExp);
      lastRd = 1; lastBk = b;
    end else lastRd = 0;
    @(negedge clk);
    chk(!rspValid, {tag, " R12 pulse"}, 32'(rspValid), 0);
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin
      cRd[b] = 31; cWr[b] = 31; cBf[b] = 31; cBn[b] = 31; cTurn[b] = 15; cType[b] = 1;
      cBus16[b] = 1; cDev16[b] = 1; cProt[b] = 0;
      for (int i = 0; i < 256; i++) begin
        mem[b][i] = 8'((b * 37 + i * 5 + 3) & 255);
        expMem[b][i] = 8'((b * 37 + i * 5 + 3) & 255);
      end
    end
    repeat (3) @(negedge clk);
    chk(reqReady && !rspValid, "R12 reset ready", {30'b0, reqReady, rspValid}, 2);
    chk(memOeN && memWeN && !memDoe, "R3 reset strobes", {29'b0, memOeN, memWeN, memDoe}, 6);
    idleChk("reset");
    rstN = 1;
    // R2: reset configuration gives a 32-cycle read on bank 0.
    doAccess(32'h0000_0010, 0, 2'd1, 0, 0, 0, "R2");
    setCfg(1, 2, 1, 0, 0, 2, 0, 1, 1, 0);
    // Write after read: turnaround, ignored high address bits, split word.
    doAccess(32'hF700_0020, 1, 2'd2, 32'hCAFE_1234, 0, 0, "R7");
    doAccess(32'h0400_0020, 0, 2'd2, 0, 0, 0, "R3");
    doAccess(32'h0400_0025, 1, 2'd0, 32'h0000_00A5, 0, 0, "R4");
    doAccess(32'h0400_0024, 0, 2'd1, 0, 0, 0, "R9");
    setCfg(2, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    doAccess(32'h0800_0040, 1, 2'd2, 32'h8877_6655, 0, 0, "R10");
    doAccess(32'h0800_0040, 0, 2'd2, 0, 0, 0, "R10");
    doAccess(32'h0800_0041, 0, 2'd1, 0, 0, 0, "R10");
    setCfg(3, 7, 3, 3, 1, 1, 3, 1, 1, 1);
    doAccess(32'h0C00_0000, 0, 2'd2, 0, 0, 0, "R5");
    doAccess(32'h0C00_0004, 0, 2'd2, 0, 1, 0, "R5");
    doAccess(32'h0C00_0008, 1, 2'd2, 32'hDEAD_BEEF, 0, 0, "R8");
    doAccess(32'h0C00_0008, 0, 2'd2, 0, 0, 0, "R8");
    doAccess(32'h0C00_000C, 0, 2'd2, 0, 1, 3, "R6");
    doAccess(32'h0400_0020, 0, 2'd2, 0, 0, 4, "R6");
    doAccess(32'h0400_0030, 1, 2'd1, 32'h0000_7E81, 0, 2, "R6");
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule